// File: doc/BRIEF.md
# Complex Vector Arithmetic Core

This core is the arithmetic engine of a multi-antenna decoder accelerator. Each operand is a complex vector with one element per receive antenna. Every real and imaginary part is a signed 16-bit Q1.15 word. A 3-bit operation code, sampled on an enabled clock edge, sends the operands to one of three units. The first adds or subtracts two pairs of complex vectors element by element. The second forms a complete vector-by-matrix product in one cycle, using one complex dot-product lane per output element. The third returns the reciprocals of the real parts of the first vector, using a small seed table and two Newton-Raphson refinements.

Results land in output registers together with a one-cycle valid strobe. Add, subtract and multiply commands are single-cycle. The reciprocal takes three enabled cycles, and new commands are ignored while it runs. When the enable input is low the core is frozen. Operation codes that name no unit here, including the code kept for the rotation unit, are ignored.

Vector element `j` sits at bits `[j*16 +: 16]` of a vector port. Matrix element (lane `k`, position `j`) sits at bits `[(k*NRX+j)*16 +: 16]` of a matrix port.

Top module: `cvec_core`

## Requirements
- R1: While `rst_n` is low, every result output is zero and `res_valid` is low.
- R2: With `mode` = 3, `res0` = `a` + `b` and `res1` = `c` + `d`, element by element on the real and imaginary parts, when `sub_sel` = 0. When `sub_sel` = 1 these become `a` − `b` and `c` − `d`.
- R3: With `mode` = 1, element `k` of `res0` is the sum over `j` of the complex product `a[j]·M[k][j]`, where M is given by `mat_re`/`mat_im`. The full-precision Q2.30 sum is shifted arithmetically right by 15 bits. `res1` is written with zero.
- R4: Every add, subtract or multiply result outside the signed 16-bit range is clamped to 32767 or −32768.
- R5: An accepted add, subtract or multiply shows its results, and `res_valid` high, in the cycle after the accepting edge. `res_valid` drops in the following cycle unless another result arrives.
- R6: With `mode` = 0, each lane of `a_re` is read as unsigned Q1.15 `x` ≥ 0x4000. The result `y` in the matching lane of `res0_re` is unsigned Q2.14 with |x·y − 2^29| ≤ 2^18. `res0_im` and `res1` are written with zero.
- R7: A reciprocal command shows its result and `res_valid` only after the third enabled edge, counting the accepting edge. `res_valid` stays low after the first two.
- R8: A reciprocal lane whose input is below 0x4000, zero included, returns exactly 0xFFFF.
- R9: Codes 2, 4, 5, 6 and 7 raise no `res_valid` and leave all result outputs unchanged.
- R10: While `enable` is low, no command is accepted, the outputs hold and `res_valid` stays low. A reciprocal in progress pauses and resumes when `enable` returns.
- R11: Commands presented while a reciprocal is in progress are ignored. Their results never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Core enable; no action while low |
| mode | input | 3 | Operation code: 0 reciprocal, 1 multiply, 3 add/subtract |
| sub_sel | input | 1 | 1 selects subtract in mode 3 |
| a_re | input | NRX*DW | Vector a, real parts (reciprocal inputs) |
| a_im | input | NRX*DW | Vector a, imaginary parts |
| b_re | input | NRX*DW | Vector b, real parts |
| b_im | input | NRX*DW | Vector b, imaginary parts |
| c_re | input | NRX*DW | Vector c, real parts |
| c_im | input | NRX*DW | Vector c, imaginary parts |
| d_re | input | NRX*DW | Vector d, real parts |
| d_im | input | NRX*DW | Vector d, imaginary parts |
| mat_re | input | NRX*NRX*DW | Matrix, real parts, one row per lane |
| mat_im | input | NRX*NRX*DW | Matrix, imaginary parts |
| res0_re | output | NRX*DW | First result vector, real |
| res0_im | output | NRX*DW | First result vector, imaginary |
| res1_re | output | NRX*DW | Second result vector, real |
| res1_im | output | NRX*DW | Second result vector, imaginary |
| res_valid | output | 1 | One-cycle strobe marking new results |

## Verification
The bench builds the core with its default parameters: four antennas, 16-bit words and a 3-bit seed index. At these values a four-term product sum of full-scale operands overruns the 16-bit range by a factor of eight, so both saturation limits of the multiply can be reached. Full-scale additions reach both limits of the add/subtract path. The reciprocal inputs span both halves of the input range, the exact 0.5 and 1.0 points, the top code and the sub-range inputs. The multicycle reciprocal is exercised with a paused enable and with a competing command presented while it runs.

// File: rtl/cvec_pkg.sv
package cvec_pkg;
  localparam int CV_DW        = 16;
  localparam int CV_NRX       = 4;
  localparam int CV_SEED_BITS = 3;

  typedef enum logic [2:0] {
    MODE_RCP = 3'd0,
    MODE_MUL = 3'd1,
    MODE_ADD = 3'd3,
    MODE_ROT = 3'd4
  } cv_mode_e;

  // clamp v to a signed w-bit range
  function automatic longint sat_s(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint addsub_s(longint x, longint y, logic sub);
    return sub ? (x - y) : (x + y);
  endfunction

  function automatic longint cmul_re(longint ar, longint ai, longint br, longint bi);
    return ar * br - ai * bi;
  endfunction

  function automatic longint cmul_im(longint ar, longint ai, longint br, longint bi);
    return ar * bi + ai * br;
  endfunction

  // seed for 1/x, x unsigned Q1.(w-1) in [0.5,2); result Q2.(w-2)
  function automatic longint rcp_seed(longint x, int w, int sb);
    longint top;
    longint idx;
    longint n;
    longint base;
    n   = longint'(1) <<< sb;
    top = (x >>> (w - 1)) & 1;
    if (top != 0) idx = (x >>> (w - 1 - sb)) & (n - 1);
    else          idx = (x >>> (w - 2 - sb)) & (n - 1);
    base = ((longint'(1) <<< (w - 2)) * 2 * n) / (2 * n + 1 + 2 * idx);
    return (top != 0) ? base : 2 * base;
  endfunction

  // one Newton-Raphson step y' = y(2 - xy), clamped to unsigned w bits
  function automatic longint rcp_step(longint x, longint y, int w);
    longint one;
    longint e;
    longint yn;
    one = longint'(1) <<< (2 * w - 3);
    e   = 2 * one - x * y;
    if (e < 0) e = 0;
    yn = (y * e) >>> (2 * w - 3);
    if (yn > (longint'(1) <<< w) - 1) yn = (longint'(1) <<< w) - 1;
    return yn;
  endfunction
endpackage

// File: rtl/cvec_addsub.sv
module cvec_addsub
  import cvec_pkg::*;
#(
  parameter int NRX = CV_NRX,
  parameter int DW  = CV_DW
) (
  input  logic              sub,
  input  logic [NRX*DW-1:0] x_re,
  input  logic [NRX*DW-1:0] x_im,
  input  logic [NRX*DW-1:0] y_re,
  input  logic [NRX*DW-1:0] y_im,
  output logic [NRX*DW-1:0] s_re,
  output logic [NRX*DW-1:0] s_im
);
  for (genvar i = 0; i < NRX; i++) begin : g_el
    longint raw_re;
    longint raw_im;
    always_comb begin
      raw_re = addsub_s(longint'($signed(x_re[i*DW +: DW])),
                        longint'($signed(y_re[i*DW +: DW])), sub);
      raw_im = addsub_s(longint'($signed(x_im[i*DW +: DW])),
                        longint'($signed(y_im[i*DW +: DW])), sub);
    end
    assign s_re[i*DW +: DW] = DW'(sat_s(raw_re, DW));
    assign s_im[i*DW +: DW] = DW'(sat_s(raw_im, DW));
  end
endmodule

// File: rtl/cvec_matmul.sv
module cvec_matmul
  import cvec_pkg::*;
#(
  parameter int NRX = CV_NRX,
  parameter int DW  = CV_DW
) (
  input  logic [NRX*DW-1:0]     v_re,
  input  logic [NRX*DW-1:0]     v_im,
  input  logic [NRX*NRX*DW-1:0] m_re,
  input  logic [NRX*NRX*DW-1:0] m_im,
  output logic [NRX*DW-1:0]     p_re,
  output logic [NRX*DW-1:0]     p_im
);
  localparam int FRAC = DW - 1;

  // one complex dot-product lane per output element
  for (genvar k = 0; k < NRX; k++) begin : g_lane
    longint acc_re;
    longint acc_im;
    always_comb begin
      acc_re = 0;
      acc_im = 0;
      for (int j = 0; j < NRX; j++) begin
        acc_re += cmul_re(longint'($signed(v_re[j*DW +: DW])),
                          longint'($signed(v_im[j*DW +: DW])),
                          longint'($signed(m_re[(k*NRX+j)*DW +: DW])),
                          longint'($signed(m_im[(k*NRX+j)*DW +: DW])));
        acc_im += cmul_im(longint'($signed(v_re[j*DW +: DW])),
                          longint'($signed(v_im[j*DW +: DW])),
                          longint'($signed(m_re[(k*NRX+j)*DW +: DW])),
                          longint'($signed(m_im[(k*NRX+j)*DW +: DW])));
      end
    end
    assign p_re[k*DW +: DW] = DW'(sat_s(acc_re >>> FRAC, DW));
    assign p_im[k*DW +: DW] = DW'(sat_s(acc_im >>> FRAC, DW));
  end
endmodule

// File: rtl/cvec_recip.sv
module cvec_recip
  import cvec_pkg::*;
#(
  parameter int NRX       = CV_NRX,
  parameter int DW        = CV_DW,
  parameter int SEED_BITS = CV_SEED_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [NRX*DW-1:0] x_vec,
  output logic              busy,
  output logic              done,
  output logic [NRX*DW-1:0] y_vec
);
  localparam int VW = NRX * DW;
  localparam logic [DW-1:0] HALF  = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] Y_LOW = {3'b001, {(DW-3){1'b0}}} - DW'(16);

  typedef enum logic [1:0] {RS_IDLE, RS_ONE, RS_TWO} rstate_e;

  rstate_e       st;
  logic [VW-1:0] x_q;
  logic [VW-1:0] y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RS_IDLE;
      x_q <= '0;
      y_q <= '0;
    end else begin
      case (st)
        RS_IDLE: if (start) begin
          x_q <= x_vec;
          for (int i = 0; i < NRX; i++)
            y_q[i*DW +: DW] <= DW'(rcp_seed(longint'(x_vec[i*DW +: DW]), DW, SEED_BITS));
          st <= RS_ONE;
        end
        RS_ONE: if (en) begin
          for (int i = 0; i < NRX; i++)
            y_q[i*DW +: DW] <= DW'(rcp_step(longint'(x_q[i*DW +: DW]),
                                            longint'(y_q[i*DW +: DW]), DW));
          st <= RS_TWO;
        end
        RS_TWO: if (en) st <= RS_IDLE;
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign busy = (st != RS_IDLE);
  assign done = (st == RS_TWO) && en;

  for (genvar l = 0; l < NRX; l++) begin : g_out
    logic [DW-1:0] y_fin;
    assign y_fin = (x_q[l*DW +: DW] < HALF) ? '1
                 : DW'(rcp_step(longint'(x_q[l*DW +: DW]), longint'(y_q[l*DW +: DW]), DW));
    assign y_vec[l*DW +: DW] = y_fin;

    AST_RCP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && x_q[l*DW +: DW] >= HALF) |-> (y_fin >= Y_LOW)); // R6
  end

  AST_RCP_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R11
  AST_RCP_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> ($stable(y_q) && busy)); // R10
endmodule

// File: rtl/cvec_core.sv
module cvec_core
  import cvec_pkg::*;
#(
  parameter int NRX       = CV_NRX,
  parameter int DW        = CV_DW,
  parameter int SEED_BITS = CV_SEED_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [2:0]            mode,
  input  logic                  sub_sel,
  input  logic [NRX*DW-1:0]     a_re,
  input  logic [NRX*DW-1:0]     a_im,
  input  logic [NRX*DW-1:0]     b_re,
  input  logic [NRX*DW-1:0]     b_im,
  input  logic [NRX*DW-1:0]     c_re,
  input  logic [NRX*DW-1:0]     c_im,
  input  logic [NRX*DW-1:0]     d_re,
  input  logic [NRX*DW-1:0]     d_im,
  input  logic [NRX*NRX*DW-1:0] mat_re,
  input  logic [NRX*NRX*DW-1:0] mat_im,
  output logic [NRX*DW-1:0]     res0_re,
  output logic [NRX*DW-1:0]     res0_im,
  output logic [NRX*DW-1:0]     res1_re,
  output logic [NRX*DW-1:0]     res1_im,
  output logic                  res_valid
);
  localparam int VW = NRX * DW;

  logic [VW-1:0] add0_re, add0_im, add1_re, add1_im;
  logic [VW-1:0] mul_re, mul_im;
  logic [VW-1:0] rcp_y;
  logic          rcp_busy, rcp_done;

  // decoded events, named for the assertions
  logic is_rcp, is_mul, is_add, mode_bad;
  logic fast_acc, rcp_start;

  assign is_rcp    = (mode == MODE_RCP);
  assign is_mul    = (mode == MODE_MUL);
  assign is_add    = (mode == MODE_ADD);
  assign mode_bad  = !(is_rcp || is_mul || is_add);
  assign fast_acc  = enable && !rcp_busy && (is_mul || is_add);
  assign rcp_start = enable && !rcp_busy && is_rcp;

  cvec_addsub #(.NRX(NRX), .DW(DW)) u_pair0 (
    .sub(sub_sel), .x_re(a_re), .x_im(a_im), .y_re(b_re), .y_im(b_im),
    .s_re(add0_re), .s_im(add0_im));

  cvec_addsub #(.NRX(NRX), .DW(DW)) u_pair1 (
    .sub(sub_sel), .x_re(c_re), .x_im(c_im), .y_re(d_re), .y_im(d_im),
    .s_re(add1_re), .s_im(add1_im));

  cvec_matmul #(.NRX(NRX), .DW(DW)) u_mul (
    .v_re(a_re), .v_im(a_im), .m_re(mat_re), .m_im(mat_im),
    .p_re(mul_re), .p_im(mul_im));

  cvec_recip #(.NRX(NRX), .DW(DW), .SEED_BITS(SEED_BITS)) u_rcp (
    .clk(clk), .rst_n(rst_n), .en(enable), .start(rcp_start), .x_vec(a_re),
    .busy(rcp_busy), .done(rcp_done), .y_vec(rcp_y));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res0_re   <= '0;
      res0_im   <= '0;
      res1_re   <= '0;
      res1_im   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= fast_acc || rcp_done;
      if (fast_acc) begin
        res0_re <= is_add ? add0_re : mul_re;
        res0_im <= is_add ? add0_im : mul_im;
        res1_re <= is_add ? add1_re : '0;
        res1_im <= is_add ? add1_im : '0;
      end else if (rcp_done) begin
        res0_re <= rcp_y;
        res0_im <= '0;
        res1_re <= '0;
        res1_im <= '0;
      end
    end
  end

  AST_FAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fast_acc |=> res_valid); // R5
  AST_RCP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rcp_start |=> !res_valid); // R7
  AST_BAD_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !rcp_busy && mode_bad) |=> (!res_valid && $stable(res0_re) && $stable(res1_im))); // R9
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!res_valid && $stable(res0_re) && $stable(res0_im)
                 && $stable(res1_re) && $stable(res1_im))); // R10
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (rcp_busy && !rcp_done) |=> !res_valid); // R11
endmodule

// File: tb/test_cvec_core.sv
`timescale 1ns/1ps
module test_cvec_core;
  localparam int NRX = 4;
  localparam int DW  = 16;
  localparam int VW  = NRX * DW;
  localparam int MW  = NRX * NRX * DW;

  // stimulus table: [23:21] mode, [20] sub_sel, [19:16] operand kind, [15:0] seed
  localparam logic [23:0] STIM [11] = '{
    24'h601234, 24'h70BEEF, 24'h610000, 24'h730000, 24'h620000, 24'h700F0F,
    24'h200101, 24'h207A5C, 24'h210000, 24'h230000, 24'h220000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0] mode = 3'd2;
  logic sub_sel = 1'b0;
  logic [VW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic [VW-1:0] c_re = '0, c_im = '0, d_re = '0, d_im = '0;
  logic [MW-1:0] mat_re = '0, mat_im = '0;
  logic [VW-1:0] res0_re, res0_im, res1_re, res1_im;
  logic res_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cvec_core #(.NRX(NRX), .DW(DW)) i_cvec_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .sub_sel(sub_sel),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .c_re(c_re), .c_im(c_im), .d_re(d_re), .d_im(d_im),
    .mat_re(mat_re), .mat_im(mat_im),
    .res0_re(res0_re), .res0_im(res0_im), .res1_re(res1_re), .res1_im(res1_im),
    .res_valid(res_valid));

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] opv(int kind, int seed, int which, int idx);
    int unsigned h;
    case (kind)
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return (which < 2) ? 16'h7FFF : 16'h8000;
      default: begin
        h = seed * 31 + which * 977 + idx * 131 + 7;
        h = h * 32'h9E3779B1;
        return h[28:13];
      end
    endcase
  endfunction

  function automatic longint clip(longint v);
    if (v > 32767) return 32767;
    else if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint sx(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic load_ops(int kind, int seed);
    for (int i = 0; i < NRX; i++) begin
      a_re[i*DW +: DW] = opv(kind, seed, 0, i);
      a_im[i*DW +: DW] = opv(kind, seed, 1, i);
      b_re[i*DW +: DW] = opv(kind, seed, 2, i);
      b_im[i*DW +: DW] = opv(kind, seed, 3, i);
      c_re[i*DW +: DW] = opv(kind, seed, 4, i);
      c_im[i*DW +: DW] = opv(kind, seed, 5, i);
      d_re[i*DW +: DW] = opv(kind, seed, 6, i);
      d_im[i*DW +: DW] = opv(kind, seed, 7, i);
    end
    for (int e = 0; e < NRX * NRX; e++) begin
      mat_re[e*DW +: DW] = opv(kind, seed, 8, e);
      mat_im[e*DW +: DW] = opv(kind, seed, 9, e);
    end
  endtask

  // R2 / R4 model: element-wise, then clamp
  task automatic check_add(bit sub);
    longint s;
    for (int i = 0; i < NRX; i++) begin
      s = sub ? sx(a_re[i*DW +: DW]) - sx(b_re[i*DW +: DW]) : sx(a_re[i*DW +: DW]) + sx(b_re[i*DW +: DW]);
      chk(sx(res0_re[i*DW +: DW]) == clip(s), "R2 R4 res0_re", 64'(res0_re[i*DW +: DW]), 64'(clip(s)));
      s = sub ? sx(a_im[i*DW +: DW]) - sx(b_im[i*DW +: DW]) : sx(a_im[i*DW +: DW]) + sx(b_im[i*DW +: DW]);
      chk(sx(res0_im[i*DW +: DW]) == clip(s), "R2 R4 res0_im", 64'(res0_im[i*DW +: DW]), 64'(clip(s)));
      s = sub ? sx(c_re[i*DW +: DW]) - sx(d_re[i*DW +: DW]) : sx(c_re[i*DW +: DW]) + sx(d_re[i*DW +: DW]);
      chk(sx(res1_re[i*DW +: DW]) == clip(s), "R2 R4 res1_re", 64'(res1_re[i*DW +: DW]), 64'(clip(s)));
      s = sub ? sx(c_im[i*DW +: DW]) - sx(d_im[i*DW +: DW]) : sx(c_im[i*DW +: DW]) + sx(d_im[i*DW +: DW]);
      chk(sx(res1_im[i*DW +: DW]) == clip(s), "R2 R4 res1_im", 64'(res1_im[i*DW +: DW]), 64'(clip(s)));
    end
  endtask

  // R3 / R4 model: accumulate exact products, drop 15 fraction bits, clamp
  task automatic check_mul();
    longint er, ei, ar, ai, mr, mi;
    for (int k = 0; k < NRX; k++) begin
      er = 0; ei = 0;
      for (int j = 0; j < NRX; j++) begin
        ar = sx(a_re[j*DW +: DW]); ai = sx(a_im[j*DW +: DW]);
        mr = sx(mat_re[(k*NRX+j)*DW +: DW]); mi = sx(mat_im[(k*NRX+j)*DW +: DW]);
        er = er + ar * mr - ai * mi;
        ei = ei + ar * mi + ai * mr;
      end
      er = clip(er >>> 15);
      ei = clip(ei >>> 15);
      chk(sx(res0_re[k*DW +: DW]) == er, "R3 R4 lane re", 64'(res0_re[k*DW +: DW]), 64'(er));
      chk(sx(res0_im[k*DW +: DW]) == ei, "R3 R4 lane im", 64'(res0_im[k*DW +: DW]), 64'(ei));
    end
    chk(res1_re == '0 && res1_im == '0, "R3 res1 zero", 64'(res1_re), 64'd0);
  endtask

  task automatic check_rcp(logic [VW-1:0] xs);
    longint x, y, err;
    for (int i = 0; i < NRX; i++) begin
      x = longint'(xs[i*DW +: DW]);
      y = longint'(res0_re[i*DW +: DW]);
      if (x < 16384) begin
        chk(y == 65535, "R8 low input", 64'(y), 64'hFFFF);
      end else begin
        err = x * y - (longint'(1) <<< 29);
        if (err < 0) err = -err;
        chk(err <= (longint'(1) <<< 18), "R6 reciprocal accuracy", 64'(y), 64'(x));
      end
    end
    chk(res0_im == '0 && res1_re == '0 && res1_im == '0, "R6 other outputs zero", 64'(res0_im), 64'd0);
  endtask

  initial begin : main
    logic [4*VW-1:0] snap;
    logic [VW-1:0] xs;
    repeat (2) @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid in reset", 64'(res_valid), 64'd0);
    chk({res0_re, res0_im, res1_re, res1_im} == '0, "R1 outputs in reset", 64'(res0_re), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: add/subtract and multiply
    for (int e = 0; e < 11; e++) begin
      load_ops(int'(STIM[e][19:16]), int'(STIM[e][15:0]));
      mode = STIM[e][23:21];
      sub_sel = STIM[e][20];
      enable = 1'b1;
      @(negedge clk);
      enable = 1'b0;
      chk(res_valid == 1'b1, "R5 valid after accept", 64'(res_valid), 64'd1);
      if (STIM[e][23:21] == 3'd3) check_add(STIM[e][20]);
      else check_mul();
      @(negedge clk);
      chk(res_valid == 1'b0, "R5 valid is a pulse", 64'(res_valid), 64'd0);
    end

    // reciprocal timing, with a competing add presented while busy (R7, R11)
    xs = {16'h5A5A, 16'hFFFF, 16'h8000, 16'h4000};
    a_re = xs;
    mode = 3'd0;
    enable = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 no valid after first edge", 64'(res_valid), 64'd0);
    load_ops(0, 16'h3333);
    mode = 3'd3;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 no valid after second edge", 64'(res_valid), 64'd0);
    @(negedge clk);
    chk(res_valid == 1'b1, "R7 valid after third edge", 64'(res_valid), 64'd1);
    enable = 1'b0;
    check_rcp(xs);
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 no late result", 64'(res_valid), 64'd0);
    check_rcp(xs);

    // reciprocal of sub-range inputs, paused by enable (R8, R10)
    xs = {16'hC000, 16'h0001, 16'h3FFF, 16'h0000};
    a_re = xs;
    mode = 3'd0;
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R10 paused reciprocal", 64'(res_valid), 64'd0);
    end
    enable = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 resumed step", 64'(res_valid), 64'd0);
    @(negedge clk);
    chk(res_valid == 1'b1, "R10 resumed completion", 64'(res_valid), 64'd1);
    enable = 1'b0;
    check_rcp(xs);

    // unused codes (R9)
    snap = {res0_re, res0_im, res1_re, res1_im};
    foreach (STIM[q]) begin
      if (q < 5) begin
        load_ops(0, 100 + q);
        case (q)
          0: mode = 3'd2;
          1: mode = 3'd4;
          2: mode = 3'd5;
          3: mode = 3'd6;
          default: mode = 3'd7;
        endcase
        enable = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R9 no valid for unused code", 64'(res_valid), 64'd0);
        chk({res0_re, res0_im, res1_re, res1_im} == snap, "R9 outputs held", 64'(res0_re), 64'(snap[4*VW-1 -: 64]));
      end
    end

    // disabled add (R10)
    enable = 1'b0;
    mode = 3'd3;
    load_ops(1, 0);
    @(negedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 no valid while disabled", 64'(res_valid), 64'd0);
    chk({res0_re, res0_im, res1_re, res1_im} == snap, "R10 outputs held", 64'(res0_re), 64'(snap[4*VW-1 -: 64]));

    // reset returns outputs to zero (R1)
    rst_n = 1'b0;
    @(negedge clk);
    chk({res0_re, res0_im, res1_re, res1_im} == '0 && !res_valid, "R1 reset clears", 64'(res0_re), 64'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule